// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block picks which page frame to give up when a new page must be brought into a fixed pool of frames. It keeps, for every frame, a loaded flag, a recently-used flag, a modified flag and a small sweep counter. A single circular hand walks the frames. While the pool still has empty slots, the hand fills them one after another. Once every slot is full, the hand rests on the oldest page and gives each page several sweeps before evicting it. A page that was used since the last sweep has its used flag and counter reset. A page that was not used counts one sweep more. A clean page goes after `CLEAN_CHANCES` idle sweeps. A modified page gets `DIRTY_CHANCES` idle sweeps and asks for a write-back one sweep before its last chance.

Page accesses arrive on a strobe with a frame index and a write flag. A replace request starts a search. The search examines one frame per clock cycle and ends with a one-cycle `done` pulse that carries the victim index. The page that fills the chosen slot starts with all of its flags and its counter cleared. The hand then moves to the next slot. Write-back requests are reported on their own pulse with the frame index. The disk transfer itself happens outside this block.

Top module: `clock_nchance_victim`

## Requirements
- R1: After reset, `done` and `wb_valid` are 0, every slot is empty and the hand points at slot 0.
- R2: When the hand rests on an empty slot, a replace request picks that slot after exactly one examination. From reset, successive requests therefore fill slots 0, 1, 2, 3 in that order.
- R3: The search examines one frame per clock cycle. If a request is sampled at clock edge E0 and k frames are examined, `done` is high for exactly one cycle following edge E0+k, and `victim` holds the chosen index at that time.
- R4: An access strobe (`acc_valid`=1) to a loaded frame sets that frame's used flag. When the hand examines a frame whose used flag is 1, it clears the flag and the sweep counter and moves on without evicting the frame.
- R5: An unused clean frame is evicted when its counter plus one reaches `CLEAN_CHANCES` (default 1, so on the first idle examination).
- R6: A write access (`acc_write`=1) sets the frame's modified flag. When the hand examines an unused modified frame and its counter plus one equals `DIRTY_CHANCES`-1 (default 1), the block pulses `wb_valid` with `wb_frame` set to that frame, clears the modified flag, keeps the frame, and moves on. The frame is evicted as a clean frame on a later sweep.
- R7: A newly loaded page starts with its used flag, modified flag and counter at zero. After a victim is chosen, the hand points at (victim+1) mod `NUM_FRAMES`.
- R8: When all frames are full, clean and used, a request examines `NUM_FRAMES`+1 frames and evicts the frame the hand started on.
- R9: An access sampled in the same cycle that the hand examines that frame is dropped. An access to any other frame during a search takes effect.
- R10: A replace request that arrives while a search is in progress is ignored and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe for one frame |
| acc_frame | input | IDX_W | Frame index of the access |
| acc_write | input | 1 | Access is a write (marks the frame modified) |
| repl_req | input | 1 | Start a victim search (ignored while one is running) |
| done | output | 1 | One-cycle pulse: the search finished |
| victim | output | IDX_W | Chosen slot, valid while `done` is high |
| wb_valid | output | 1 | One-cycle pulse: a modified frame needs write-back |
| wb_frame | output | IDX_W | Frame to write back while `wb_valid` is high |

## Verification
An access takes effect at the clock edge that samples it. The `done` and `wb_valid` pulses appear right after the edge at which the hand examines the deciding frame, so a result is due k cycles after the request edge when k frames are examined. The bench raises each stimulus on a falling edge. After every later falling edge it counts one examination, notes any write-back pulse, and checks the victim, the examination count and the set of written-back frames once `done` is seen. Dropped or extra activity is checked the same way. A side access or a second request is placed on the exact falling edge before the examination it should collide with. After that, the resulting victim and latency are compared, and the bench confirms that no `done` appears in the cycles after the pulse.

// File: rtl/clock_nchance_pkg.sv
package clock_nchance_pkg;

   // Operation the hand applies to the frame it is examining
   typedef enum logic [2:0] {
      OP_NONE,
      OP_PASS,     // used flag was set: clear it and the counter
      OP_AGE,      // idle: counter + 1
      OP_AGE_WB,   // idle and modified: counter + 1, write-back, clear modified
      OP_LOAD      // chosen: slot refilled with a fresh page
   } slot_op_e;

endpackage

// File: rtl/nchance_slot.sv
module nchance_slot
   import clock_nchance_pkg::*;
#(
   parameter int CNT_W   = 2,
   parameter int CNT_MAX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_en,
   input  slot_op_e         op,
   input  logic             acc_hit,
   input  logic             acc_wr,
   output logic             valid_o,
   output logic             use_o,
   output logic             dirty_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic             valid_q, use_q, dirty_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         use_q   <= 1'b0;
         dirty_q <= 1'b0;
         cnt_q   <= '0;
      end else if (op_en) begin
         // the hand owns the slot this cycle; a colliding access is dropped
         unique case (op)
            OP_PASS: begin
               use_q <= 1'b0;
               cnt_q <= '0;
            end
            OP_AGE:  cnt_q <= cnt_q + 1'b1;
            OP_AGE_WB: begin
               cnt_q   <= cnt_q + 1'b1;
               dirty_q <= 1'b0;
            end
            OP_LOAD: begin
               valid_q <= 1'b1;
               use_q   <= 1'b0;
               dirty_q <= 1'b0;
               cnt_q   <= '0;
            end
            default: ;
         endcase
      end else if (acc_hit && valid_q) begin
         use_q <= 1'b1;
         if (acc_wr) dirty_q <= 1'b1;
      end
   end

   assign valid_o = valid_q;
   assign use_o   = use_q;
   assign dirty_o = dirty_q;
   assign cnt_o   = cnt_q;

   // R6: the sweep counter never passes the largest chance count
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/nchance_hand_ctrl.sv
module nchance_hand_ctrl
   import clock_nchance_pkg::*;
#(
   parameter int NUM_FRAMES    = 4,
   parameter int CLEAN_CHANCES = 1,
   parameter int DIRTY_CHANCES = 2,
   parameter int IDX_W         = 2,
   parameter int CNT_W         = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             repl_req,
   input  logic             ex_valid,
   input  logic             ex_use,
   input  logic             ex_dirty,
   input  logic [CNT_W-1:0] ex_cnt,
   output logic [IDX_W-1:0] hand_o,
   output logic             searching_o,
   output slot_op_e         op_o,
   output logic             done_o,
   output logic [IDX_W-1:0] victim_o,
   output logic             wb_valid_o,
   output logic [IDX_W-1:0] wb_frame_o
);

   logic [IDX_W-1:0] hand_q, victim_q, wb_frame_q;
   logic             searching_q, done_q, wb_valid_q;
   logic [CNT_W-1:0] next_cnt;
   logic             early_wb_hit;
   logic             wb_now;
   slot_op_e         op;

   assign next_cnt = ex_cnt + 1'b1;

   // Variant: early write-back exists only when modified frames get extra sweeps
   generate
      if (DIRTY_CHANCES > CLEAN_CHANCES) begin : g_early_wb
         assign early_wb_hit = (next_cnt == CNT_W'(DIRTY_CHANCES - 1));
      end else begin : g_no_early_wb
         assign early_wb_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      op     = OP_NONE;
      wb_now = 1'b0;
      if (searching_q) begin
         if (!ex_valid) begin
            op = OP_LOAD;
         end else if (ex_use) begin
            op = OP_PASS;
         end else if (ex_dirty) begin
            if (next_cnt >= CNT_W'(DIRTY_CHANCES)) begin
               op     = OP_LOAD;
               wb_now = 1'b1;
            end else if (early_wb_hit) begin
               op     = OP_AGE_WB;
               wb_now = 1'b1;
            end else begin
               op = OP_AGE;
            end
         end else if (next_cnt >= CNT_W'(CLEAN_CHANCES)) begin
            op = OP_LOAD;
         end else begin
            op = OP_AGE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hand_q      <= '0;
         searching_q <= 1'b0;
         done_q      <= 1'b0;
         victim_q    <= '0;
         wb_valid_q  <= 1'b0;
         wb_frame_q  <= '0;
      end else begin
         done_q     <= 1'b0;
         wb_valid_q <= 1'b0;
         if (!searching_q) begin
            searching_q <= repl_req;
         end else begin
            hand_q <= (hand_q == IDX_W'(NUM_FRAMES - 1)) ? '0 : hand_q + 1'b1;
            if (op == OP_LOAD) begin
               searching_q <= 1'b0;
               done_q      <= 1'b1;
               victim_q    <= hand_q;
            end
            if (wb_now) begin
               wb_valid_q <= 1'b1;
               wb_frame_q <= hand_q;
            end
         end
      end
   end

   assign hand_o      = hand_q;
   assign searching_o = searching_q;
   assign op_o        = op;
   assign done_o      = done_q;
   assign victim_o    = victim_q;
   assign wb_valid_o  = wb_valid_q;
   assign wb_frame_o  = wb_frame_q;

   // R3: completion is a single-cycle pulse
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R10: a request is never taken while a search runs; done ends the search
   p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !searching_q);

endmodule

// File: rtl/clock_nchance_victim.sv
module clock_nchance_victim
   import clock_nchance_pkg::*;
#(
   parameter  int NUM_FRAMES    = 4,
   parameter  int CLEAN_CHANCES = 1,
   parameter  int DIRTY_CHANCES = 2,
   localparam int IDX_W         = $clog2(NUM_FRAMES),
   localparam int CNT_W         = $clog2(DIRTY_CHANCES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_frame,
   input  logic             acc_write,
   input  logic             repl_req,
   output logic             done,
   output logic [IDX_W-1:0] victim,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_frame
);

   initial begin
      assert (NUM_FRAMES >= 2) else $error("NUM_FRAMES must be at least 2");
      assert (CLEAN_CHANCES >= 1) else $error("CLEAN_CHANCES must be at least 1");
      assert (DIRTY_CHANCES >= CLEAN_CHANCES)
         else $error("DIRTY_CHANCES must not be below CLEAN_CHANCES");
   end

   logic [NUM_FRAMES-1:0] valid_v, use_v, dirty_v;
   logic [CNT_W-1:0]      cnt_v [NUM_FRAMES];
   logic [IDX_W-1:0]      hand;
   logic                  searching;
   slot_op_e              op;

   nchance_hand_ctrl #(
      .NUM_FRAMES   (NUM_FRAMES),
      .CLEAN_CHANCES(CLEAN_CHANCES),
      .DIRTY_CHANCES(DIRTY_CHANCES),
      .IDX_W        (IDX_W),
      .CNT_W        (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .repl_req   (repl_req),
      .ex_valid   (valid_v[hand]),
      .ex_use     (use_v[hand]),
      .ex_dirty   (dirty_v[hand]),
      .ex_cnt     (cnt_v[hand]),
      .hand_o     (hand),
      .searching_o(searching),
      .op_o       (op),
      .done_o     (done),
      .victim_o   (victim),
      .wb_valid_o (wb_valid),
      .wb_frame_o (wb_frame)
   );

   generate
      for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_slot
         nchance_slot #(
            .CNT_W  (CNT_W),
            .CNT_MAX(DIRTY_CHANCES)
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .op_en  (searching && (hand == IDX_W'(i))),
            .op     (op),
            .acc_hit(acc_valid && (acc_frame == IDX_W'(i))),
            .acc_wr (acc_write),
            .valid_o(valid_v[i]),
            .use_o  (use_v[i]),
            .dirty_o(dirty_v[i]),
            .cnt_o  (cnt_v[i])
         );
      end
   endgenerate

   // R7: the slot reported as victim holds a fresh page when done fires
   p_victim_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (valid_v[victim] && !use_v[victim] && !dirty_v[victim]
                && cnt_v[victim] == '0));

   // R6: an early write-back leaves the reported frame unmodified
   p_wb_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !done) |-> !dirty_v[wb_frame]);

endmodule

// File: tb/test_clock_nchance_victim.sv
`timescale 1ns/100ps
module test_clock_nchance_victim;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       acc_valid, acc_write, repl_req;
   logic [1:0] acc_frame;
   logic       done, wb_valid;
   logic [1:0] victim, wb_frame;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   clock_nchance_victim i_clock_nchance_victim (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
      .repl_req(repl_req), .done(done), .victim(victim),
      .wb_valid(wb_valid), .wb_frame(wb_frame)
   );

   typedef struct packed {
      logic       is_acc;
      logic [1:0] frm;
      logic       wr;
      logic [1:0] ev;    // expected victim
      logic [3:0] el;    // expected frames examined
      logic [3:0] ewb;   // expected write-back mask
      logic [3:0] req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 1'b0, 2'd0, 4'd1, 4'b0000, 4'd2},  // R2 fill
      '{1'b0, 2'd0, 1'b0, 2'd1, 4'd1, 4'b0000, 4'd2},
      '{1'b0, 2'd0, 1'b0, 2'd2, 4'd1, 4'b0000, 4'd2},
      '{1'b0, 2'd0, 1'b0, 2'd3, 4'd1, 4'b0000, 4'd2},
      '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 4'b0000, 4'd4},  // R4 read 0
      '{1'b1, 2'd1, 1'b1, 2'd0, 4'd0, 4'b0000, 4'd6},  // R6 write 1
      '{1'b0, 2'd0, 1'b0, 2'd2, 4'd3, 4'b0000, 4'd4},  // R4 skip 0,1
      '{1'b0, 2'd0, 1'b0, 2'd3, 4'd1, 4'b0000, 4'd5},  // R5
      '{1'b0, 2'd0, 1'b0, 2'd0, 4'd1, 4'b0000, 4'd5},
      '{1'b0, 2'd0, 1'b0, 2'd2, 4'd2, 4'b0010, 4'd6},  // R6 wb of 1
      '{1'b0, 2'd0, 1'b0, 2'd3, 4'd1, 4'b0000, 4'd7},  // R7 fresh page
      '{1'b0, 2'd0, 1'b0, 2'd0, 4'd1, 4'b0000, 4'd7},
      '{1'b0, 2'd0, 1'b0, 2'd1, 4'd1, 4'b0000, 4'd6},  // R6 later sweep
      '{1'b1, 2'd0, 1'b0, 2'd0, 4'd0, 4'b0000, 4'd4},
      '{1'b1, 2'd1, 1'b0, 2'd0, 4'd0, 4'b0000, 4'd4},
      '{1'b1, 2'd2, 1'b0, 2'd0, 4'd0, 4'b0000, 4'd4},
      '{1'b1, 2'd3, 1'b0, 2'd0, 4'd0, 4'b0000, 4'd4},
      '{1'b0, 2'd0, 1'b0, 2'd2, 4'd5, 4'b0000, 4'd8},  // R8 full sweep
      '{1'b1, 2'd3, 1'b1, 2'd0, 4'd0, 4'b0000, 4'd6},
      '{1'b1, 2'd0, 1'b1, 2'd0, 4'd0, 4'b0000, 4'd6},
      '{1'b0, 2'd0, 1'b0, 2'd1, 4'd3, 4'b0000, 4'd4},
      '{1'b0, 2'd0, 1'b0, 2'd2, 4'd1, 4'b0000, 4'd7},
      '{1'b0, 2'd0, 1'b0, 2'd1, 4'd3, 4'b1001, 4'd6}   // R6 two write-backs
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_frame = '0; repl_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_acc(input logic [1:0] f, input logic w);
      @(negedge clk);
      acc_valid = 1'b1; acc_frame = f; acc_write = w;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   // side_acc / side_req: iteration on which an extra access / request is sampled
   task automatic run_repl(input int ev, input int el, input int ewb, input string rq,
                           input int side_acc, input logic [1:0] side_frm, input int side_req);
      int lat = 0;
      int mask = 0;
      bit got = 0;
      @(negedge clk);
      repl_req = 1'b1;
      @(negedge clk);
      repl_req = 1'b0;
      for (int i = 0; i < 60 && !got; i++) begin
         acc_valid = (i == side_acc);
         acc_frame = side_frm;
         acc_write = 1'b0;
         repl_req  = (i == side_req);
         @(negedge clk);
         acc_valid = 1'b0;
         repl_req  = 1'b0;
         lat = i + 1;
         if (wb_valid) mask = mask | (1 << wb_frame);
         if (done) got = 1;
      end
      chk(got, {rq, " done seen"}, got, 1);
      chk(victim == 2'(ev), {rq, " victim"}, victim, ev);
      chk(lat == el, "R3 frames examined", lat, el);
      chk(mask == ewb, "R6 write-back mask", mask, ewb);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk(wb_valid == 1'b0, "R1 wb_valid after reset", wb_valid, 0);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v].is_acc)
            do_acc(VEC[v].frm, VEC[v].wr);
         else
            run_repl(VEC[v].ev, VEC[v].el, VEC[v].ewb,
                     $sformatf("R%0d", VEC[v].req), -1, 2'd0, -1);
      end

      // R9: access to frame 0 in the cycle the hand examines it is dropped
      do_reset();
      for (int f = 0; f < 4; f++) run_repl(f, 1, 0, "R2", -1, 2'd0, -1);
      for (int f = 0; f < 4; f++) do_acc(2'(f), 1'b0);
      run_repl(0, 5, 0, "R9 dropped access", 0, 2'd0, -1);

      // R9 / R10: access to a passed frame counts; request mid-search ignored
      do_reset();
      for (int f = 0; f < 4; f++) run_repl(f, 1, 0, "R2", -1, 2'd0, -1);
      for (int f = 0; f < 4; f++) do_acc(2'(f), 1'b0);
      run_repl(1, 6, 0, "R9 access off hand", 1, 2'd0, 2);
      begin
         int extra = 0;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk(extra == 0, "R10 no extra done", extra, 0);
         chk(extra == 0, "R3 done single pulse", extra, 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule